// File: doc/BRIEF.md
# Feature Access Gating Register Bank

This block sits between a host's 32-bit memory-mapped bus and the register space of a set of power-management features. For every feature it keeps a 32-bit state word holding an enable flag, separate read and write blocking flags, an out-of-band select flag, an 8-bit feature identifier and a lock flag. Each host access to a feature's registers is filtered against that feature's state word. A blocked read returns all ones. A blocked write is dropped without any sign on the bus. A feature that is not enabled is treated as blocked in both directions.

A privileged configuration port programs the state words, including the feature identifier. The host may also rewrite the flag bits of an unlocked state word. The host can always read every state word, so software can find out how each feature is gated before it touches it. The bank also holds a 64-bit platform information register with fields for function, device, bus and package. Once software sets its lock flag, the register stays read-only until reset. The feature registers themselves are modelled as a plain array of words behind the gate.

Top module: `fgate_bank`

## Requirements
- R1: After reset every state word, both halves of the info register and every feature register are zero. Because every feature then reads as disabled, a read of any feature register returns 0xFFFFFFFF.
- R2: State word bit positions are: enable 0, write-block 4, read-block 5, out-of-band select 6, feature ID 15:8, locked 31. Every other bit reads as zero, so a configuration write of 0xFFFFFFFF reads back as 0x8000FF71.
- R3: While read-block (bit 5) of an enabled feature is set, a host read of any of that feature's registers returns 0xFFFFFFFF. The stored contents are untouched and reappear once the block is cleared.
- R4: While write-block (bit 4) of an enabled feature is set, a host write to that feature's registers changes nothing. Reads of that feature are still served.
- R5: A feature whose enable bit (bit 0) is 0 returns 0xFFFFFFFF on reads and drops writes, whatever its two block bits say.
- R6: A host write to an unlocked state word updates bits 0, 4, 5, 6 and 31 and leaves the feature ID unchanged. While the locked bit is set, host writes to that state word have no effect.
- R7: The configuration port (cfg_we, cfg_feat, cfg_wdata) writes a whole state word even when it is locked. A configuration write and a host write to the same word in the same cycle resolve in favour of the configuration port. The locked bit, once set, stays set until reset.
- R8: A host read of a state word returns its current contents, even when that feature is read-blocked or disabled.
- R9: The info register holds function in bits 2:0, device in 7:3, bus in 15:8, package in 23:16 and a lock flag in bit 63. All other bits read as zero. Once bit 63 is 1, host writes to either half are ignored until reset.
- R10: With host_addr MSB set, the low address bits select control registers: index f < NUM_FEAT is state word f, index NUM_FEAT is info bits 31:0, and NUM_FEAT+1 is info bits 63:32. Any other index reads zero and ignores writes. A read request is answered with host_rvalid and host_rdata exactly one cycle later. A write request produces no host_rvalid.
- R11: With host_addr MSB clear, word address f*2^ceil(log2(REGS_PER_FEAT)) + r selects register r of feature f. An enabled, unblocked feature stores and returns written data, and the features do not disturb one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, one cycle per access |
| host_we | input | 1 | 1 for write, 0 for read |
| host_addr | input | ADDR_W | Host word address (MSB selects control space) |
| host_wdata | input | 32 | Host write data |
| host_rvalid | output | 1 | Read response valid, one cycle after a read request |
| host_rdata | output | 32 | Read response data |
| cfg_we | input | 1 | Privileged state word write strobe |
| cfg_feat | input | FEAT_W | Feature selected by the privileged write |
| cfg_wdata | input | 32 | Privileged state word value |

## Verification
A corrupted state word shows up on the host bus at the next access to the affected feature. A gating flag that is stuck on or off turns the response into 0xFFFFFFFF, or fails to, in the cycle after the read request. A write that leaks through a block only becomes visible once the block is lifted and the same register is read back. For that reason every blocking scenario ends with a release and a readback. A lock bit that clears early is caught the next time the host tries to write the state word or the info register, and the bench reads the word straight after every such write.

// File: rtl/fgate_pkg.sv
package fgate_pkg;

    localparam int WORD_W = 32;
    localparam int INFO_W = 64;

    // Per-feature gating word; bit positions are decoded by host software.
    typedef struct packed {
        logic        locked;    // 31
        logic [14:0] rsv_hi;    // 30:16
        logic [7:0]  feat_id;   // 15:8
        logic        rsv7;      // 7
        logic        oob_sel;   // 6
        logic        rd_blk;    // 5
        logic        wr_blk;    // 4
        logic [2:0]  rsv_lo;    // 3:1
        logic        enable;    // 0
    } state_word_t;

    // Platform information register.
    typedef struct packed {
        logic        lock;      // 63
        logic [38:0] rsv;       // 62:24
        logic [7:0]  pkg;       // 23:16
        logic [7:0]  bus;       // 15:8
        logic [4:0]  dev;       // 7:3
        logic [2:0]  fn;        // 2:0
    } info_t;

    typedef enum logic [2:0] {
        SP_NONE,
        SP_FEAT,
        SP_STATE,
        SP_INFO_LO,
        SP_INFO_HI
    } space_e;

    function automatic state_word_t st_clean(logic [WORD_W-1:0] w);
        state_word_t s;
        s        = state_word_t'(w);
        s.rsv_hi = '0;
        s.rsv7   = 1'b0;
        s.rsv_lo = '0;
        return s;
    endfunction

    // Host update: identifier is owned by the configuration port.
    function automatic state_word_t st_host_merge(state_word_t old, logic [WORD_W-1:0] w);
        state_word_t s;
        s         = st_clean(w);
        s.feat_id = old.feat_id;
        return s;
    endfunction

    // Configuration update: lock can be raised but never dropped.
    function automatic state_word_t st_cfg_merge(state_word_t old, logic [WORD_W-1:0] w);
        state_word_t s;
        s        = st_clean(w);
        s.locked = s.locked | old.locked;
        return s;
    endfunction

    function automatic logic rd_gated(state_word_t s);
        return !s.enable || s.rd_blk;
    endfunction

    function automatic logic wr_gated(state_word_t s);
        return !s.enable || s.wr_blk;
    endfunction

    function automatic info_t info_clean(logic [INFO_W-1:0] w);
        info_t i;
        i     = info_t'(w);
        i.rsv = '0;
        return i;
    endfunction

endpackage

// File: rtl/fgate_state.sv
module fgate_state #(
    parameter int NUM_FEAT = 4,
    parameter int FEAT_W   = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   host_we,
    input  logic [FEAT_W-1:0]                      host_idx,
    input  logic [fgate_pkg::WORD_W-1:0]           host_wdata,
    input  logic                                   cfg_we,
    input  logic [FEAT_W-1:0]                      cfg_feat,
    input  logic [fgate_pkg::WORD_W-1:0]           cfg_wdata,
    output fgate_pkg::state_word_t [NUM_FEAT-1:0]  st_q
);
    import fgate_pkg::*;

    for (genvar f = 0; f < NUM_FEAT; f++) begin : g_word
        state_word_t word_q;
        logic        cfg_hit;
        logic        host_hit;

        assign cfg_hit  = cfg_we  && (cfg_feat == FEAT_W'(f));
        assign host_hit = host_we && (host_idx == FEAT_W'(f)) && !word_q.locked;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (cfg_hit) begin
                word_q <= st_cfg_merge(word_q, cfg_wdata);
            end else if (host_hit) begin
                word_q <= st_host_merge(word_q, host_wdata);
            end
        end

        assign st_q[f] = word_q;
    end

endmodule

// File: rtl/fgate_info.sv
module fgate_info (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_lo,
    input  logic                          wr_hi,
    input  logic [fgate_pkg::WORD_W-1:0]  wdata,
    output fgate_pkg::info_t              info_q
);
    import fgate_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            info_q <= '0;
        end else if (!info_q.lock) begin
            if (wr_lo) begin
                info_q <= info_clean({info_q[INFO_W-1:WORD_W], wdata});
            end else if (wr_hi) begin
                info_q <= info_clean({wdata, info_q[WORD_W-1:0]});
            end
        end
    end

endmodule

// File: rtl/fgate_store.sv
module fgate_store #(
    parameter int DEPTH = 32,
    parameter int IDX_W = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [IDX_W-1:0]              idx,
    input  logic [fgate_pkg::WORD_W-1:0]  wdata,
    output logic [fgate_pkg::WORD_W-1:0]  rdata
);
    import fgate_pkg::*;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rdata = mem_q[idx];

endmodule

// File: rtl/fgate_bank.sv
module fgate_bank #(
    parameter int NUM_FEAT      = 4,
    parameter int REGS_PER_FEAT = 8,
    parameter int FEAT_W        = (NUM_FEAT > 1) ? $clog2(NUM_FEAT) : 1,
    parameter int REG_W         = (REGS_PER_FEAT > 1) ? $clog2(REGS_PER_FEAT) : 1,
    parameter int ADDR_W        = FEAT_W + REG_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic              host_rvalid,
    output logic [31:0]       host_rdata,
    input  logic              cfg_we,
    input  logic [FEAT_W-1:0] cfg_feat,
    input  logic [31:0]       cfg_wdata
);
    import fgate_pkg::*;

    localparam int LOW_W = FEAT_W + REG_W;
    localparam int SLOTS = 1 << REG_W;
    localparam int DEPTH = NUM_FEAT * SLOTS;

    state_word_t [NUM_FEAT-1:0] st_q;
    info_t                      info_q;

    logic              in_ctl;
    logic [LOW_W-1:0]  low;
    logic [FEAT_W-1:0] fsel;
    logic              feat_ok;
    space_e            sp;
    state_word_t       cur_st;
    logic [31:0]       store_rdata;
    logic              store_we;
    logic              state_we;
    logic              info_we_lo;
    logic              info_we_hi;
    logic [31:0]       rd_next;

    // Address decode.
    assign in_ctl  = host_addr[ADDR_W-1];
    assign low     = host_addr[LOW_W-1:0];
    assign fsel    = host_addr[LOW_W-1:REG_W];
    assign feat_ok = ({1'b0, fsel} < (FEAT_W+1)'(NUM_FEAT));

    always_comb begin
        sp = SP_NONE;
        if (!in_ctl) begin
            if (feat_ok) sp = SP_FEAT;
        end else if ({1'b0, low} < (LOW_W+1)'(NUM_FEAT)) begin
            sp = SP_STATE;
        end else if ({1'b0, low} == (LOW_W+1)'(NUM_FEAT)) begin
            sp = SP_INFO_LO;
        end else if ({1'b0, low} == (LOW_W+1)'(NUM_FEAT + 1)) begin
            sp = SP_INFO_HI;
        end
    end

    assign cur_st = feat_ok ? st_q[fsel] : '0;

    // Write strobes.
    assign store_we   = host_req && host_we && (sp == SP_FEAT) && !wr_gated(cur_st);
    assign state_we   = host_req && host_we && (sp == SP_STATE);
    assign info_we_lo = host_req && host_we && (sp == SP_INFO_LO);
    assign info_we_hi = host_req && host_we && (sp == SP_INFO_HI);

    fgate_state #(
        .NUM_FEAT (NUM_FEAT),
        .FEAT_W   (FEAT_W)
    ) i_state (
        .clk        (clk),
        .rst        (rst),
        .host_we    (state_we),
        .host_idx   (low[FEAT_W-1:0]),
        .host_wdata (host_wdata),
        .cfg_we     (cfg_we),
        .cfg_feat   (cfg_feat),
        .cfg_wdata  (cfg_wdata),
        .st_q       (st_q)
    );

    fgate_info i_info (
        .clk    (clk),
        .rst    (rst),
        .wr_lo  (info_we_lo),
        .wr_hi  (info_we_hi),
        .wdata  (host_wdata),
        .info_q (info_q)
    );

    fgate_store #(
        .DEPTH (DEPTH),
        .IDX_W (LOW_W)
    ) i_store (
        .clk   (clk),
        .rst   (rst),
        .we    (store_we),
        .idx   (low),
        .wdata (host_wdata),
        .rdata (store_rdata)
    );

    // Read mux, registered for a fixed one-cycle response.
    always_comb begin
        rd_next = '0;
        unique case (sp)
            SP_FEAT:    rd_next = rd_gated(cur_st) ? '1 : store_rdata;
            SP_STATE:   rd_next = st_q[low[FEAT_W-1:0]];
            SP_INFO_LO: rd_next = info_q[31:0];
            SP_INFO_HI: rd_next = info_q[63:32];
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= host_req && !host_we;
            if (host_req && !host_we) begin
                host_rdata <= rd_next;
            end
        end
    end

endmodule

// File: rtl/fgate_chk.sv
module fgate_chk #(
    parameter int NUM_FEAT = 4,
    parameter int FEAT_W   = 2,
    parameter int REG_W    = 3,
    parameter int ADDR_W   = 6
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           host_req,
    input logic                           host_we,
    input logic [ADDR_W-1:0]              host_addr,
    input logic                           host_rvalid,
    input logic [31:0]                    host_rdata,
    input logic                           cfg_we,
    input logic [FEAT_W-1:0]              cfg_feat,
    input logic [NUM_FEAT-1:0][31:0]      st_words,
    input logic [63:0]                    info_q
);
    localparam int LOW_W = FEAT_W + REG_W;

    logic              rd_req;
    logic [FEAT_W-1:0] fidx;
    logic              fidx_ok;
    logic              feat_rd_blocked;
    logic              state_rd;
    logic [31:0]       sel_word;

    assign rd_req          = host_req && !host_we;
    assign fidx            = host_addr[LOW_W-1:REG_W];
    assign fidx_ok         = ({1'b0, fidx} < (FEAT_W+1)'(NUM_FEAT));
    assign feat_rd_blocked = rd_req && !host_addr[ADDR_W-1] && fidx_ok &&
                             (!st_words[fidx][0] || st_words[fidx][5]);
    assign state_rd        = rd_req && host_addr[ADDR_W-1] &&
                             ({1'b0, host_addr[LOW_W-1:0]} < (LOW_W+1)'(NUM_FEAT));
    assign sel_word        = st_words[host_addr[FEAT_W-1:0]];

    // R10
    rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> host_rvalid);

    // R10
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !host_rvalid);

    // R3
    rd_block_ones_chk: assert property (@(posedge clk) disable iff (rst)
        feat_rd_blocked |=> (host_rdata == 32'hFFFF_FFFF));

    // R8
    state_visible_chk: assert property (@(posedge clk) disable iff (rst)
        state_rd |=> (host_rdata == $past(sel_word)));

    // R9
    info_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        info_q[63] |=> $stable(info_q));

    for (genvar f = 0; f < NUM_FEAT; f++) begin : g_feat
        // R7
        lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            st_words[f][31] |=> st_words[f][31]);

        // R6
        locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (st_words[f][31] && !(cfg_we && cfg_feat == FEAT_W'(f))) |=> $stable(st_words[f]));
    end

endmodule

bind fgate_bank fgate_chk #(
    .NUM_FEAT (NUM_FEAT),
    .FEAT_W   (FEAT_W),
    .REG_W    (REG_W),
    .ADDR_W   (ADDR_W)
) u_fgate_chk (
    .clk         (clk),
    .rst         (rst),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_rvalid (host_rvalid),
    .host_rdata  (host_rdata),
    .cfg_we      (cfg_we),
    .cfg_feat    (cfg_feat),
    .st_words    (st_q),
    .info_q      (info_q)
);

// File: tb/test_fgate_bank.sv
module test_fgate_bank;

    localparam int ADDR_W = 6;
    // Address map at default parameters (4 features, 8 registers each)
    localparam logic [5:0] A_ST0     = 6'd32;
    localparam logic [5:0] A_ST2     = 6'd34;
    localparam logic [5:0] A_ST3     = 6'd35;
    localparam logic [5:0] A_INFO_LO = 6'd36;
    localparam logic [5:0] A_INFO_HI = 6'd37;
    localparam logic [5:0] A_UNMAP   = 6'd40;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_req = 1'b0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [31:0]       host_wdata = '0;
    logic              host_rvalid;
    logic [31:0]       host_rdata;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_feat = '0;
    logic [31:0]       cfg_wdata = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    fgate_bank i_fgate_bank (
        .clk         (clk),
        .rst         (rst),
        .host_req    (host_req),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rvalid (host_rvalid),
        .host_rdata  (host_rdata),
        .cfg_we      (cfg_we),
        .cfg_feat    (cfg_feat),
        .cfg_wdata   (cfg_wdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic host_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_req = 1'b0;
        v = host_rvalid;
        d = host_rdata;
    endtask

    task automatic read_expect(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic        v;
        host_read(a, d, v);
        check({req, " rvalid"}, {31'd0, v}, 32'd1);
        check(req, d, exp);
    endtask

    task automatic cfg_write(input logic [1:0] f, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_feat = f; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset_state();
        read_expect("R1 state word f0 after reset", A_ST0, 32'h0);
        read_expect("R1 info lo after reset", A_INFO_LO, 32'h0);
        read_expect("R1 disabled feature reads ones", 6'd2, 32'hFFFF_FFFF);
    endtask

    task automatic t_layout();
        cfg_write(2'd3, 32'h7FFF_FF7F);
        read_expect("R2 reserved bits zero", A_ST3, 32'h0000_FF71);
    endtask

    task automatic t_open_access();
        cfg_write(2'd0, 32'h0000_0A01);
        cfg_write(2'd2, 32'h0000_0201);
        host_write(6'd2, 32'h1234_5678);
        host_write(6'd5, 32'hCAFE_F00D);
        host_write(6'd18, 32'h0BAD_BEEF);
        read_expect("R11 f0 reg2 readback", 6'd2, 32'h1234_5678);
        read_expect("R11 f0 reg5 readback", 6'd5, 32'hCAFE_F00D);
        read_expect("R11 f2 reg2 independent", 6'd18, 32'h0BAD_BEEF);
    endtask

    task automatic t_read_block();
        cfg_write(2'd0, 32'h0000_0A21);
        read_expect("R3 read-blocked returns ones", 6'd2, 32'hFFFF_FFFF);
        read_expect("R8 state word visible when blocked", A_ST0, 32'h0000_0A21);
        cfg_write(2'd0, 32'h0000_0A01);
        read_expect("R3 contents intact after unblock", 6'd2, 32'h1234_5678);
    endtask

    task automatic t_write_block();
        cfg_write(2'd0, 32'h0000_0A11);
        host_write(6'd2, 32'hDEAD_BEEF);
        read_expect("R4 write dropped, read served", 6'd2, 32'h1234_5678);
        cfg_write(2'd0, 32'h0000_0A01);
        read_expect("R4 write still absent after unblock", 6'd2, 32'h1234_5678);
    endtask

    task automatic t_disabled();
        cfg_write(2'd0, 32'h0000_0A00);
        host_write(6'd2, 32'h0000_1111);
        read_expect("R5 disabled reads ones", 6'd2, 32'hFFFF_FFFF);
        read_expect("R8 state word visible when disabled", A_ST0, 32'h0000_0A00);
        cfg_write(2'd0, 32'h0000_0A01);
        read_expect("R5 disabled write dropped", 6'd2, 32'h1234_5678);
    endtask

    task automatic t_host_state();
        host_write(A_ST2, 32'h0000_5531);
        read_expect("R6 host write keeps ID", A_ST2, 32'h0000_0231);
        host_write(A_ST2, 32'h8000_0001);
        read_expect("R6 host sets lock", A_ST2, 32'h8000_0201);
        host_write(A_ST2, 32'h0000_0000);
        read_expect("R6 locked word ignores host", A_ST2, 32'h8000_0201);
        host_write(6'd17, 32'h0000_0042);
        read_expect("R11 locked open feature still usable", 6'd17, 32'h0000_0042);
    endtask

    task automatic t_cfg_locked();
        cfg_write(2'd2, 32'h0000_0311);
        read_expect("R7 cfg updates locked word, lock kept", A_ST2, 32'h8000_0311);
        // same-cycle collision on f3: configuration wins
        @(negedge clk);
        cfg_we = 1'b1; cfg_feat = 2'd3; cfg_wdata = 32'h0000_0C01;
        host_req = 1'b1; host_we = 1'b1; host_addr = A_ST3; host_wdata = 32'h0000_0031;
        @(negedge clk);
        cfg_we = 1'b0; host_req = 1'b0; host_we = 1'b0;
        read_expect("R7 cfg wins collision", A_ST3, 32'h0000_0C01);
    endtask

    task automatic t_info();
        host_write(A_INFO_LO, 32'hFFFF_FFFF);
        read_expect("R9 info lo reserved zero", A_INFO_LO, 32'h00FF_FFFF);
        host_write(A_INFO_HI, 32'h7FFF_FFFF);
        read_expect("R9 info hi reserved zero", A_INFO_HI, 32'h0);
        host_write(A_INFO_LO, 32'h0012_3456);
        read_expect("R9 info fields", A_INFO_LO, 32'h0012_3456);
        host_write(A_INFO_HI, 32'h8000_0000);
        read_expect("R9 info lock set", A_INFO_HI, 32'h8000_0000);
        host_write(A_INFO_LO, 32'h0);
        read_expect("R9 locked info lo frozen", A_INFO_LO, 32'h0012_3456);
        host_write(A_INFO_HI, 32'h0);
        read_expect("R9 locked info hi frozen", A_INFO_HI, 32'h8000_0000);
    endtask

    task automatic t_timing();
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 6'd3; host_wdata = 32'h5;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
        check("R10 no response to write", {31'd0, host_rvalid}, 32'd0);
        host_write(A_UNMAP, 32'hFFFF_FFFF);
        read_expect("R10 unmapped control reads zero", A_UNMAP, 32'h0);
        @(negedge clk);
        check("R10 rvalid single cycle", {31'd0, host_rvalid}, 32'd0);
    endtask

    task automatic t_reset_clears_lock();
        do_reset();
        read_expect("R7 reset clears locked word", A_ST2, 32'h0);
        read_expect("R1 reset clears info lock", A_INFO_HI, 32'h0);
        cfg_write(2'd0, 32'h0000_0001);
        read_expect("R1 feature registers cleared", 6'd2, 32'h0);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_layout();
        t_open_access();
        t_read_block();
        t_write_block();
        t_disabled();
        t_host_state();
        t_cfg_locked();
        t_info();
        t_timing();
        t_reset_clears_lock();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule